// File: doc/BRIEF.md
# Capture/Reload/Baud Timer

This block is a counter of parameterised width (16 bits by default). It is paired with a capture/reload register of the same width and an 8-bit control byte. The counter advances on an internal machine-cycle tick or on falling edges of an external count pin. Each time it wraps from all ones, one of three things happens. In reload mode it takes the value of the capture/reload register. In capture mode it wraps to zero. In baud mode it always reloads, so its overflow pulses can serve as the bit clock of a serial port.

A second pin, the trigger, acts on its falling edges when the external-enable bit is set. In reload mode such an edge forces a reload. In capture mode it copies the running count into the capture/reload register. In both cases it sets an external-event flag, which is kept apart from the overflow flag. Baud mode suppresses the overflow flag and mutes the trigger pin. In baud mode with the internal source, the counter steps once every second system clock. This means a reload value `V` yields a serial bit rate of fclk / (32 × (2^16 − V)) once the serial port divides by 16. For the receive side and the transmit side, two select outputs each pick either this timer's overflow pulse or an external timer's overflow pulse.

Top module: `cap_reload_tmr`

## Requirements
- R1: After reset, all five registers read 0 and the flag, interrupt and baud-pulse outputs are 0.
- R2: With the run bit (control bit 2) set and the source bit (control bit 1) clear, outside baud mode, the count rises by one on every clock in which `tick_i` is high. With the run bit clear, or with `tick_i` low, the count holds.
- R3: With the run bit and the source bit set, the count rises by one per falling edge of `cnt_pin_i` and ignores `tick_i`.
- R4: In reload mode (control bit 0 clear), a step from all ones loads the count from the capture/reload register and sets the overflow flag (control bit 7).
- R5: In reload mode with the external-enable bit (control bit 3) set, a falling edge on `trig_pin_i` loads the count from the capture/reload register and sets the external flag (control bit 6). With that enable clear, the edge changes nothing.
- R6: In capture mode (control bit 0 set) with external enable set, a trigger falling edge copies the count into the capture/reload register and sets the external flag. An overflow wraps the count to 0 and sets the overflow flag.
- R7: In baud mode (control bit 5 or bit 4 set), the overflow flag is never set, the count reloads on overflow even when control bit 0 is set, and the trigger pin causes no capture, reload or flag.
- R8: In baud mode with the internal source, the count steps once every second clock while running.
- R9: `rx_baud_o` carries the timer's own registered overflow pulse when control bit 5 is set, and `t1_ovf_i` otherwise. `tx_baud_o` does the same under control bit 4. `rx_sel_o` and `tx_sel_o` show those bits.
- R10: Both flags stay set until software writes the control byte with that bit at 0. `irq_o` is high whenever either flag is set.
- R11: Address 0 is the control byte, addresses 1 and 2 are the count low and high bytes, and addresses 3 and 4 are the capture/reload low and high bytes. Each reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count enable, one pulse per machine cycle |
| cnt_pin_i | input | 1 | External count pin, counted on falling edges |
| trig_pin_i | input | 1 | External capture/reload trigger pin |
| t1_ovf_i | input | 1 | Overflow pulse of the other baud source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External trigger flag |
| irq_o | output | 1 | Interrupt request, OR of both flags |
| rx_sel_o | output | 1 | Receive clock uses this timer |
| tx_sel_o | output | 1 | Transmit clock uses this timer |
| rx_baud_o | output | 1 | Receive baud pulse |
| tx_baud_o | output | 1 | Transmit baud pulse |

## Verification
The hardest case to reach is the baud-mode half-rate step landing exactly on the overflow. It needs the prescaler phase, the reload and the registered pulse to line up in a known cycle. The stimulus loads count and reload value both to two below the top, then starts the timer with a single control write. From that write the bench counts clock edges, predicts the edge on which the receive pulse appears, and checks the counts in the following two cycles. A trigger edge is then sent while baud mode is running with external enable and capture mode set. This shows that the capture register and both flags stay untouched.

// File: rtl/crt_pkg.sv
package crt_pkg;

   // Control byte; the bit order is fixed because software decodes it.
   typedef struct packed {
      logic ovf_flag;   // bit 7
      logic ext_flag;   // bit 6
      logic rx_sel;     // bit 5
      logic tx_sel;     // bit 4
      logic ext_en;     // bit 3
      logic run;        // bit 2
      logic src_ext;    // bit 1
      logic cap_mode;   // bit 0
   } crt_ctrl_t;

   localparam int CRT_BYTE_W = 8;

   function automatic logic crt_is_baud(crt_ctrl_t c);
      return c.rx_sel | c.tx_sel;
   endfunction

endpackage

// File: rtl/crt_pin_sync.sv
module crt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fall_o
);

   logic [STAGES:0] stg_q;

   generate
      for (genvar s = 0; s <= STAGES; s++) begin : g_stg
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= 1'b0;
               else        stg_q[0] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= 1'b0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   // Falling edge: the older sample is high, the newer one is low.
   assign fall_o = stg_q[STAGES] & ~stg_q[STAGES-1];

endmodule

// File: rtl/crt_step_gen.sv
module crt_step_gen #(
   parameter int BAUD_PRESCALE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic src_ext_i,
   input  logic baud_i,
   input  logic tick_i,
   input  logic ext_fall_i,
   output logic inc_o
);

   logic baud_step;
   logic int_step;

   generate
      if (BAUD_PRESCALE == 1) begin : g_nodiv
         assign baud_step = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(BAUD_PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(BAUD_PRESCALE - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (run_i && baud_i && !src_ext_i)
               pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
            else
               pre_q <= '0;
         end
         assign baud_step = (pre_q == LAST);
      end
   endgenerate

   assign int_step = baud_i ? baud_step : tick_i;
   assign inc_o    = run_i & (src_ext_i ? ext_fall_i : int_step);

endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
   import crt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we_i,
   input  logic [7:0] wr_data_i,
   input  logic      set_ovf_i,
   input  logic      set_ext_i,
   output crt_ctrl_t ctrl_o
);

   crt_ctrl_t ctrl_q;
   crt_ctrl_t ctrl_d;

   // Hardware flag sets take priority over a software write in the same cycle.
   always_comb begin
      ctrl_d = ctrl_q;
      if (we_i)      ctrl_d          = crt_ctrl_t'(wr_data_i);
      if (set_ovf_i) ctrl_d.ovf_flag = 1'b1;
      if (set_ext_i) ctrl_d.ext_flag = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   assign ctrl_o = ctrl_q;

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core #(
   parameter  int CNT_W = 16,
   localparam int NB    = CNT_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             trig_i,
   input  logic             reload_mode_i,
   input  logic [NB-1:0]    cnt_we_i,
   input  logic [NB-1:0]    cap_we_i,
   input  logic [7:0]       wr_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             ovf_o
);

   logic [CNT_W-1:0] cnt_q, cap_q;
   logic [CNT_W-1:0] cnt_hw, cap_hw;
   logic [CNT_W-1:0] cnt_d, cap_d;

   assign ovf_o = inc_i & (&cnt_q);

   always_comb begin
      cnt_hw = cnt_q;
      if (inc_i)                  cnt_hw = cnt_q + CNT_W'(1);
      if (ovf_o)                  cnt_hw = reload_mode_i ? cap_q : '0;
      if (trig_i && reload_mode_i) cnt_hw = cap_q;
      cap_hw = cap_q;
      if (trig_i && !reload_mode_i) cap_hw = cnt_q;
   end

   // Software byte writes override the hardware update lane by lane.
   generate
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign cnt_d[b*8 +: 8] = cnt_we_i[b] ? wr_data_i : cnt_hw[b*8 +: 8];
         assign cap_d[b*8 +: 8] = cap_we_i[b] ? wr_data_i : cap_hw[b*8 +: 8];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cap_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         cap_q <= cap_d;
      end
   end

   assign cnt_o = cnt_q;
   assign cap_o = cap_q;

endmodule

// File: rtl/cap_reload_tmr.sv
module cap_reload_tmr
   import crt_pkg::*;
#(
   parameter  int CNT_W         = 16,
   parameter  int SYNC_STAGES   = 2,
   parameter  int BAUD_PRESCALE = 2,
   localparam int NB            = CNT_W / 8,
   localparam int ADDR_W        = $clog2(2 * NB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              cnt_pin_i,
   input  logic              trig_pin_i,
   input  logic              t1_ovf_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              ovf_flag_o,
   output logic              ext_flag_o,
   output logic              irq_o,
   output logic              rx_sel_o,
   output logic              tx_sel_o,
   output logic              rx_baud_o,
   output logic              tx_baud_o
);

   generate
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_width
         $error("CNT_W must be a non-zero multiple of 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (BAUD_PRESCALE < 1) begin : g_bad_pre
         $error("BAUD_PRESCALE must be at least 1");
      end
   endgenerate

   crt_ctrl_t        ctrl_q;
   logic             baud;
   logic             cnt_fall, trig_fall;
   logic             inc, trig_evt, core_ovf, ovf_q;
   logic             ctrl_we;
   logic [NB-1:0]    cnt_we, cap_we;
   logic [CNT_W-1:0] cnt_q, cap_q;

   assign baud     = crt_is_baud(ctrl_q);
   assign ctrl_we  = wr_en_i && (wr_addr_i == '0);
   assign trig_evt = trig_fall & ctrl_q.ext_en & ~baud;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_dec
         assign cnt_we[b] = wr_en_i && (wr_addr_i == ADDR_W'(1 + b));
         assign cap_we[b] = wr_en_i && (wr_addr_i == ADDR_W'(1 + NB + b));
      end
   endgenerate

   crt_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cnt_pin_i),
      .fall_o (cnt_fall)
   );

   crt_pin_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (trig_pin_i),
      .fall_o (trig_fall)
   );

   crt_step_gen #(.BAUD_PRESCALE(BAUD_PRESCALE)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (ctrl_q.run),
      .src_ext_i  (ctrl_q.src_ext),
      .baud_i     (baud),
      .tick_i     (tick_i),
      .ext_fall_i (cnt_fall),
      .inc_o      (inc)
   );

   crt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .inc_i         (inc),
      .trig_i        (trig_evt),
      .reload_mode_i (~ctrl_q.cap_mode | baud),
      .cnt_we_i      (cnt_we),
      .cap_we_i      (cap_we),
      .wr_data_i     (wr_data_i),
      .cnt_o         (cnt_q),
      .cap_o         (cap_q),
      .ovf_o         (core_ovf)
   );

   crt_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (ctrl_we),
      .wr_data_i (wr_data_i),
      .set_ovf_i (core_ovf & ~baud),
      .set_ext_i (trig_evt),
      .ctrl_o    (ctrl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= core_ovf;
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == '0) rd_data_o = ctrl_q;
      for (int b = 0; b < NB; b++) begin
         if (rd_addr_i == ADDR_W'(1 + b))      rd_data_o = cnt_q[b*8 +: 8];
         if (rd_addr_i == ADDR_W'(1 + NB + b)) rd_data_o = cap_q[b*8 +: 8];
      end
   end

   assign ovf_flag_o = ctrl_q.ovf_flag;
   assign ext_flag_o = ctrl_q.ext_flag;
   assign irq_o      = ctrl_q.ovf_flag | ctrl_q.ext_flag;
   assign rx_sel_o   = ctrl_q.rx_sel;
   assign tx_sel_o   = ctrl_q.tx_sel;
   assign rx_baud_o  = ctrl_q.rx_sel ? ovf_q : t1_ovf_i;
   assign tx_baud_o  = ctrl_q.tx_sel ? ovf_q : t1_ovf_i;

endmodule

// File: rtl/crt_sva.sv
module crt_sva
   import crt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input crt_ctrl_t         ctrl_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [CNT_W-1:0]  cnt_i,
   input logic [CNT_W-1:0]  cap_i,
   input logic              ovf_i
);

   logic ctrl_wr;
   logic baud;
   assign ctrl_wr = wr_en_i && (wr_addr_i == '0);
   assign baud    = ctrl_i.rx_sel | ctrl_i.tx_sel;

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i.run && !ctrl_i.ext_en && !wr_en_i) |=> $stable(cnt_i)); // R2

   AST_RELOAD_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && $past(!ctrl_i.cap_mode || baud) && $past(!wr_en_i))
      |-> (cnt_i == $past(cap_i))); // R4

   AST_WRAP_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && $past(ctrl_i.cap_mode && !baud) && $past(!wr_en_i))
      |-> (cnt_i == '0)); // R6

   AST_BAUD_NO_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (baud && !ctrl_i.ovf_flag && !ctrl_wr) |=> !ctrl_i.ovf_flag); // R7

   AST_BAUD_NO_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (baud && !ctrl_i.ext_flag && !ctrl_wr) |=> !ctrl_i.ext_flag); // R7

   AST_OVF_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i.ovf_flag && !ctrl_wr) |=> ctrl_i.ovf_flag); // R10

   AST_EXT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i.ext_flag && !ctrl_wr) |=> ctrl_i.ext_flag); // R10

endmodule

bind cap_reload_tmr crt_sva #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_i    (ctrl_q),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .cnt_i     (cnt_q),
   .cap_i     (cap_q),
   .ovf_i     (ovf_q)
);

// File: tb/cap_reload_tmr_tb_top.sv
`timescale 1ns/1ps
module cap_reload_tmr_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, cnt_pin_i = 1'b0, trig_pin_i = 1'b0, t1_ovf_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_addr_i = '0, rd_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic       ovf_flag_o, ext_flag_o, irq_o, rx_sel_o, tx_sel_o, rx_baud_o, tx_baud_o;

   always #4 clk = ~clk;   // 125 MHz

   cap_reload_tmr dut_i (.*);

   // Observation selectors: 0..4 register addresses, 8.. output ports.
   localparam int S_OVF = 8, S_EXT = 9, S_IRQ = 10, S_RXB = 11, S_TXB = 12,
                  S_RXS = 13, S_TXS = 14;

   typedef struct {
      string      req;
      int         sel;
      logic [7:0] exp;
   } item_t;

   item_t q[$];
   event  push_ev, pop_ev;
   int    checks = 0, errors = 0;
   bit    done = 1'b0;

   function automatic logic [7:0] observe(int sel);
      case (sel)
         S_OVF:   return {7'd0, ovf_flag_o};
         S_EXT:   return {7'd0, ext_flag_o};
         S_IRQ:   return {7'd0, irq_o};
         S_RXB:   return {7'd0, rx_baud_o};
         S_TXB:   return {7'd0, tx_baud_o};
         S_RXS:   return {7'd0, rx_sel_o};
         S_TXS:   return {7'd0, tx_sel_o};
         default: return rd_data_o;
      endcase
   endfunction

   // Monitor: pops expected items and compares them with the design.
   initial begin
      forever begin
         @(push_ev);
         if (q[0].sel < 8) rd_addr_i = 3'(q[0].sel);
         #0.1;
         checks++;
         if (observe(q[0].sel) !== q[0].exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%h expected=%h",
                     q[0].req, q[0].sel, observe(q[0].sel), q[0].exp);
         end
         void'(q.pop_front());
         -> pop_ev;
      end
   end

   // Driver side of the scoreboard.
   task automatic chk(string req, int sel, int exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = 8'(exp);
      q.push_back(it);
      -> push_ev;
      @(pop_ev);
   endtask

   task automatic wr(int a, int d);
      wr_addr_i = 3'(a);
      wr_data_i = 8'(d);
      wr_en_i   = 1'b1;
      @(negedge clk);
      wr_en_i   = 1'b0;
   endtask

   task automatic trig_pulse();
      trig_pin_i = 1'b1;
      repeat (4) @(negedge clk);
      trig_pin_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 5; a++) chk("R1 reset register", a, 0);
      chk("R1 reset irq", S_IRQ, 0);
      chk("R1 reset ovf flag", S_OVF, 0);
      chk("R1 reset rx pulse", S_RXB, 0);

      // R2 internal counting, one step per tick
      tick_i = 1'b1;
      wr(0, 8'h04);
      repeat (9) @(negedge clk);
      wr(0, 8'h00);
      chk("R2 count low", 1, 10);
      chk("R2 count high", 2, 0);
      repeat (5) @(negedge clk);
      chk("R2 hold when stopped", 1, 10);
      tick_i = 1'b0;
      wr(0, 8'h04);
      repeat (6) @(negedge clk);
      wr(0, 8'h00);
      chk("R2 hold with tick low", 1, 10);
      tick_i = 1'b1;

      // R11 register map
      wr(3, 8'hA5);
      wr(4, 8'h5A);
      chk("R11 capture low", 3, 8'hA5);
      chk("R11 capture high", 4, 8'h5A);
      wr(0, 8'h30);
      chk("R11 control readback", 0, 8'h30);
      chk("R9 rx select", S_RXS, 1);
      chk("R9 tx select", S_TXS, 1);
      wr(0, 8'h00);

      // R3 external pin counting
      wr(1, 0);
      wr(2, 0);
      wr(0, 8'h06);
      for (int i = 0; i < 5; i++) begin
         cnt_pin_i = 1'b1;
         repeat (3) @(negedge clk);
         cnt_pin_i = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      wr(0, 8'h00);
      chk("R3 external count low", 1, 5);
      chk("R3 external count high", 2, 0);

      // R4 reload on overflow
      wr(3, 8'h34);
      wr(4, 8'h12);
      wr(1, 8'hFE);
      wr(2, 8'hFF);
      wr(0, 8'h04);
      repeat (2) @(negedge clk);
      chk("R4 overflow flag", S_OVF, 1);
      chk("R4 reloaded low", 1, 8'h34);
      chk("R4 reloaded high", 2, 8'h12);
      chk("R4 control with flag", 0, 8'h84);
      chk("R10 irq from overflow flag", S_IRQ, 1);
      wr(0, 8'h00);
      chk("R4 count after reload", 1, 8'h35);
      chk("R10 overflow flag cleared by write", S_OVF, 0);
      chk("R10 irq cleared", S_IRQ, 0);

      // R5 reload from trigger pin
      wr(1, 8'h55);
      wr(2, 8'h00);
      wr(0, 8'h08);
      trig_pulse();
      chk("R5 trigger reload low", 1, 8'h34);
      chk("R5 trigger reload high", 2, 8'h12);
      chk("R5 control with ext flag", 0, 8'h48);
      chk("R5 ext flag", S_EXT, 1);
      chk("R10 irq from ext flag", S_IRQ, 1);
      wr(0, 8'h00);
      chk("R10 ext flag cleared by write", S_EXT, 0);
      wr(1, 8'h55);
      trig_pulse();
      chk("R5 trigger ignored without enable", 1, 8'h55);
      chk("R5 no flag without enable", 0, 8'h00);

      // R6 capture mode
      wr(1, 8'h21);
      wr(2, 8'h43);
      wr(0, 8'h09);
      trig_pulse();
      chk("R6 captured low", 3, 8'h21);
      chk("R6 captured high", 4, 8'h43);
      chk("R6 count unchanged", 1, 8'h21);
      chk("R6 ext flag", 0, 8'h49);
      wr(1, 8'hFF);
      wr(2, 8'hFF);
      wr(0, 8'h05);
      @(negedge clk);
      chk("R6 wrap low", 1, 0);
      chk("R6 wrap high", 2, 0);
      chk("R6 overflow flag", 0, 8'h85);
      chk("R6 capture kept", 3, 8'h21);
      wr(0, 8'h00);
      chk("R6 count after wrap", 1, 1);

      // R7 R8 R9 baud mode
      wr(3, 8'hFE);
      wr(4, 8'hFF);
      wr(1, 8'hFE);
      wr(2, 8'hFF);
      wr(0, 8'h25);
      repeat (4) @(negedge clk);
      chk("R9 rx pulse from own overflow", S_RXB, 1);
      chk("R7 reload despite capture bit", 1, 8'hFE);
      chk("R7 reload high", 2, 8'hFF);
      chk("R7 no overflow flag", S_OVF, 0);
      @(negedge clk);
      chk("R9 rx pulse one cycle", S_RXB, 0);
      chk("R8 no step on odd clock", 1, 8'hFE);
      @(negedge clk);
      chk("R8 step on even clock", 1, 8'hFF);
      t1_ovf_i = 1'b1;
      chk("R9 tx follows other source", S_TXB, 1);
      chk("R9 rx select shown", S_RXS, 1);
      chk("R9 tx select shown", S_TXS, 0);
      t1_ovf_i = 1'b0;
      wr(0, 8'h2D);
      trig_pulse();
      chk("R7 trigger gives no ext flag", S_EXT, 0);
      chk("R7 trigger gives no capture low", 3, 8'hFE);
      chk("R7 trigger gives no capture high", 4, 8'hFF);
      chk("R7 control has no flags", 0, 8'h2D);
      wr(0, 8'h00);
      t1_ovf_i = 1'b1;
      chk("R9 rx follows other source", S_RXB, 1);
      t1_ovf_i = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule